// File: doc/BRIEF.md
# Strided Stream Address Generator

This block supplies word addresses to a memory array that runs in streaming mode. A configuration load captures four values: a starting index, a word count, a stride, and a direction (up or down). After the load, each request pulse returns the next word address of the stream. The address space has 1024 words, and addresses wrap around at both ends.

The first request after a load returns the starting index unchanged. Each later request moves the previous address by the stride, up or down. When the programmed number of words has been issued, the block raises `done_o` and ignores any further requests until the next load. A count of zero marks the stream as finished right away.

Top module: `strided_addr_gen`

## Requirements
- R1: After reset, `addr_vld_o` is 0, `done_o` is 1 and `addr_o` is 0.
- R2: The first accepted request after a load presents the loaded starting index on `addr_o`, with `addr_vld_o` high, one cycle after the request.
- R3: With `cfg_down` = 0, each later address equals the previous address plus the stride, modulo 1024.
- R4: With `cfg_down` = 1, each later address equals the previous address minus the stride, modulo 1024.
- R5: A load with count N > 0 yields exactly N valid addresses. `done_o` rises in the same cycle as the N-th valid address.
- R6: While `done_o` is high, requests produce no `addr_vld_o`, and `addr_o` keeps the last address issued.
- R7: A load with count 0 leaves `done_o` high in the next cycle, and no request produces a valid address.
- R8: A load restarts the stream even in the middle of a stream. In the cycle after a load with a nonzero count, `done_o` is 0 and `addr_vld_o` is 0. A request in the same cycle as the load is discarded.
- R9: `addr_vld_o` is high for exactly one cycle per accepted request, in the cycle after that request. Idle gaps between requests do not disturb the address sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cfg_load | input | 1 | Capture the configuration fields and restart the stream |
| cfg_start | input | ADDR_W (10) | First word address of the stream |
| cfg_count | input | CNT_W (11) | Number of words in the stream |
| cfg_stride | input | ADDR_W (10) | Address step between consecutive words |
| cfg_down | input | 1 | 0: step upward, 1: step downward |
| req | input | 1 | Request the next stream word |
| addr_o | output | ADDR_W (10) | Registered word address |
| addr_vld_o | output | 1 | `addr_o` carries a new stream word this cycle |
| done_o | output | 1 | Stream exhausted; requests are ignored |

## Verification
The checker assumes the following about the inputs:
- All inputs are known, non-X values in every cycle after reset.
- The configuration fields matter only in a cycle where `cfg_load` is high.
- `cfg_count` never exceeds 1024 words.

The bench meets these assumptions by driving every input to a defined value from time zero. It changes inputs only on the falling edge, and it gives each stream a count no larger than the 1024-word address space. Streams are run back to back, with and without idle cycles between requests, with a request placed in the load cycle, and with a reload that cuts a stream short. This makes the checker's shadow copy of the configuration the only reference it needs.

// File: rtl/sag_pkg.sv
package sag_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } sag_dir_e;
endpackage

// File: rtl/sag_step.sv
// Next-address calculator: moves the current address by the stride in the
// selected direction; the fixed width gives modulo-2^ADDR_W wrap for free.
module sag_step
  import sag_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] cur,
  input  logic [ADDR_W-1:0] stride,
  input  sag_dir_e          dir,
  output logic [ADDR_W-1:0] nxt
);
  always_comb begin
    if (dir == DIR_DOWN) nxt = cur - stride;
    else                 nxt = cur + stride;
  end
endmodule

// File: rtl/sag_counter.sv
// Remaining-word counter: loaded with the stream length, decremented per
// accepted word; flags the final word and exhaustion.
module sag_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_cnt,
  input  logic             adv,
  output logic             last,
  output logic             empty
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)       remain_q <= '0;
    else if (load) remain_q <= load_cnt;
    else if (adv)  remain_q <= remain_q - ONE;
  end

  assign last  = (remain_q == ONE);
  assign empty = (remain_q == '0);
endmodule

// File: rtl/strided_addr_gen.sv
module strided_addr_gen
  import sag_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_load,
  input  logic [ADDR_W-1:0] cfg_start,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic [ADDR_W-1:0] cfg_stride,
  input  logic              cfg_down,
  input  logic              req,
  output logic [ADDR_W-1:0] addr_o,
  output logic              addr_vld_o,
  output logic              done_o
);
  logic [ADDR_W-1:0] cur_q;
  logic [ADDR_W-1:0] stride_q;
  sag_dir_e          dir_q;
  logic [ADDR_W-1:0] nxt_addr;
  logic              cnt_last;
  logic              cnt_empty;
  logic              accept;

  // A load always wins over a request in the same cycle.
  assign accept = req && !cfg_load && !cnt_empty;

  sag_step #(.ADDR_W(ADDR_W)) step_i (
    .cur    (cur_q),
    .stride (stride_q),
    .dir    (dir_q),
    .nxt    (nxt_addr)
  );

  sag_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk      (clk),
    .rst      (rst),
    .load     (cfg_load),
    .load_cnt (cfg_count),
    .adv      (accept),
    .last     (cnt_last),
    .empty    (cnt_empty)
  );

  // Stream state
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q    <= '0;
      stride_q <= '0;
      dir_q    <= DIR_UP;
    end else if (cfg_load) begin
      cur_q    <= cfg_start;
      stride_q <= cfg_stride;
      dir_q    <= sag_dir_e'(cfg_down);
    end else if (accept) begin
      cur_q    <= nxt_addr;
    end
  end

  // Registered outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o     <= '0;
      addr_vld_o <= 1'b0;
      done_o     <= 1'b1;
    end else begin
      addr_vld_o <= accept;
      if (accept) addr_o <= cur_q;
      if (cfg_load)                 done_o <= (cfg_count == '0);
      else if (accept && cnt_last)  done_o <= 1'b1;
    end
  end
endmodule

// File: rtl/sag_chk.sv
module sag_chk #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 11
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_load,
  input logic [ADDR_W-1:0] cfg_start,
  input logic [CNT_W-1:0]  cfg_count,
  input logic [ADDR_W-1:0] cfg_stride,
  input logic              cfg_down,
  input logic              req,
  input logic [ADDR_W-1:0] addr_o,
  input logic              addr_vld_o,
  input logic              done_o
);
  logic [ADDR_W-1:0] sh_start, sh_stride, prev_addr, exp_step;
  logic [CNT_W-1:0]  sh_count, vld_cnt;
  logic              sh_down, seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_start <= '0; sh_stride <= '0; sh_count <= '0; sh_down <= 1'b0;
      seen <= 1'b0; prev_addr <= '0; vld_cnt <= '0;
    end else if (cfg_load) begin
      sh_start <= cfg_start; sh_stride <= cfg_stride;
      sh_count <= cfg_count; sh_down <= cfg_down;
      seen <= 1'b0; vld_cnt <= '0;
    end else if (addr_vld_o) begin
      seen <= 1'b1; prev_addr <= addr_o; vld_cnt <= vld_cnt + 1'b1;
    end
  end

  assign exp_step = sh_down ? prev_addr - sh_stride : prev_addr + sh_stride;

  // R2
  first_addr_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o && !seen |-> addr_o == sh_start);
  // R3 R4
  stride_step_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o && seen |-> addr_o == exp_step);
  // R5
  count_limit_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o |-> vld_cnt < sh_count);
  // R5
  done_on_last_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o && (vld_cnt + 1'b1 == sh_count) |-> done_o);
  // R6
  idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    done_o && !cfg_load |=> !addr_vld_o);
  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !addr_vld_o |-> $stable(addr_o));
  // R7
  zero_count_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && cfg_count == '0 |=> done_o && !addr_vld_o);
  // R8
  load_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_load && cfg_count != '0 |=> !done_o && !addr_vld_o);
  // R9
  vld_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    addr_vld_o |-> $past(req) && !$past(cfg_load));
endmodule

bind strided_addr_gen sag_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_start(cfg_start),
  .cfg_count(cfg_count), .cfg_stride(cfg_stride), .cfg_down(cfg_down),
  .req(req), .addr_o(addr_o), .addr_vld_o(addr_vld_o), .done_o(done_o)
);

// File: tb/strided_addr_gen_tb_top.sv
module strided_addr_gen_tb_top;
  localparam int AW = 10;
  localparam int CW = 11;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_load = 1'b0;
  logic [AW-1:0] cfg_start = '0;
  logic [CW-1:0] cfg_count = '0;
  logic [AW-1:0] cfg_stride = '0;
  logic          cfg_down = 1'b0;
  logic          req = 1'b0;
  logic [AW-1:0] addr_o;
  logic          addr_vld_o;
  logic          done_o;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  typedef struct packed { logic [AW-1:0] a; logic last; } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;

  strided_addr_gen #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_start(cfg_start),
    .cfg_count(cfg_count), .cfg_stride(cfg_stride), .cfg_down(cfg_down),
    .req(req), .addr_o(addr_o), .addr_vld_o(addr_vld_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  // Monitor: pops expected words when the design presents a valid address
  initial begin
    forever begin
      @(posedge clk); #2;
      if (!rst && addr_vld_o) begin
        if (q.size() == 0) begin
          check(1'b0, "R6 unexpected valid", int'(addr_o), -1);
        end else begin
          exp_t e;
          e = q.pop_front();
          check(addr_o == e.a, "R2/R3/R4 address", int'(addr_o), int'(e.a));
          check(done_o == e.last, "R5 done with last word", int'(done_o), int'(e.last));
        end
      end
    end
  end

  // Driver: load a stream, issue nreq requests with gap idle cycles between
  task automatic run_stream(input int start, input int count, input int stride,
                            input bit down, input int nreq, input int gap,
                            input bit req_on_load);
    logic [AW-1:0] a;
    logic [AW-1:0] last_a;
    int issued;
    a = AW'(start);
    last_a = addr_o;
    issued = (nreq < count) ? nreq : count;
    for (int i = 0; i < issued; i++) begin
      q.push_back('{a: a, last: (i == count - 1)});
      last_a = a;
      a = down ? a - AW'(stride) : a + AW'(stride);
    end
    @(negedge clk);
    cfg_load = 1'b1; cfg_start = AW'(start); cfg_count = CW'(count);
    cfg_stride = AW'(stride); cfg_down = down; req = req_on_load;
    @(posedge clk); #2;
    // R7 R8: state right after the load
    check(done_o == (count == 0), "R7/R8 done after load", int'(done_o), int'(count == 0));
    check(addr_vld_o == 1'b0, "R8 no valid after load", int'(addr_vld_o), 0);
    @(negedge clk);
    cfg_load = 1'b0; req = 1'b0;
    for (int i = 0; i < nreq; i++) begin
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R5 word count", q.size(), 0);
    check(done_o == (nreq >= count), "R5/R6 done state", int'(done_o), int'(nreq >= count));
    if (issued > 0)
      check(addr_o == last_a, "R6 address held", int'(addr_o), int'(last_a));
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(posedge clk); #2;
    // R1
    check(addr_vld_o == 1'b0, "R1 reset valid", int'(addr_vld_o), 0);
    check(done_o == 1'b1, "R1 reset done", int'(done_o), 1);
    check(addr_o == '0, "R1 reset address", int'(addr_o), 0);
    // R6: requests before any load are ignored
    @(negedge clk); req = 1'b1; @(negedge clk); req = 1'b0;
    @(posedge clk); #2;
    check(addr_vld_o == 1'b0, "R6 request with no stream", int'(addr_vld_o), 0);
    // R2 R3 R5 R6: up stream, extra requests beyond the count
    run_stream(5, 4, 3, 1'b0, 6, 0, 1'b0);
    // R4: down stream wrapping below zero
    run_stream(2, 3, 4, 1'b1, 3, 0, 1'b0);
    // R3: up stream wrapping past 1023
    run_stream(1020, 3, 3, 1'b0, 4, 0, 1'b0);
    // R7: zero count
    run_stream(77, 0, 5, 1'b0, 3, 0, 1'b0);
    // R9: gaps between requests
    run_stream(100, 4, 7, 1'b1, 4, 2, 1'b0);
    // R8: request in the load cycle is discarded; then reload mid-stream
    run_stream(300, 5, 9, 1'b0, 2, 0, 1'b1);
    run_stream(900, 3, 100, 1'b0, 3, 1, 1'b0);
    // R5: full-length stream of 1024 words, stride 1
    run_stream(0, 1024, 1, 1'b0, 1025, 0, 1'b0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule